// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is a purely combinational shifter that forms the second operand of an integer datapath. It takes a data word, a shift kind, a shift count and the current carry flag. It returns the shifted word and the carry bit that a flag-setting operation would record. The shift kinds are logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. In that last kind the carry acts as an extra bit above the sign bit, so the rotate covers W+1 bits.

Counts of zero, of exactly the word width, and of more than the word width each have defined results and carry values. Decoding of immediate fields into a count is done upstream, and flag storage is done downstream.

Top module: `barrel_shift_unit`

## Requirements
- R1: With a count of 0 and any kind other than the carry rotate, `shift_out` equals `op_value` and `carry_out` equals `carry_in`.
- R2: Kind code 0 (logical left) with count n in 1..W-1 shifts left by n and fills the vacated low bits with zeros. `carry_out` is `op_value[W-n]`.
- R3: Kind code 1 (logical right) with count n in 1..W-1 shifts right by n and fills the vacated high bits with zeros. `carry_out` is `op_value[n-1]`.
- R4: Kind code 2 (arithmetic right) with count n in 1..W-1 shifts right by n and fills the vacated high bits with copies of `op_value[W-1]`. `carry_out` is `op_value[n-1]`.
- R5: Kind code 3 (rotate right) with a count whose remainder m modulo W is nonzero rotates right by m, so that bits leaving bit 0 re-enter at bit W-1. `carry_out` is `op_value[m-1]`.
- R6: Kind code 3 with a count that is a nonzero multiple of W returns `op_value` unchanged, and `carry_out` is `op_value[W-1]`.
- R7: Kind code 4 (carry rotate) returns `{carry_in, op_value[W-1:1]}` with `carry_out` equal to `op_value[0]`, whatever the count.
- R8: Logical left or logical right by exactly W gives 0. `carry_out` is `op_value[0]` for the left shift and `op_value[W-1]` for the right shift.
- R9: Logical left or logical right by more than W gives 0 with `carry_out` 0.
- R10: Arithmetic right by W or more sets every result bit to `op_value[W-1]`, and `carry_out` equals that same bit.
- R11: Kind codes 5, 6 and 7 are unused and pass through: `shift_out` equals `op_value` and `carry_out` equals `carry_in` for every count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_value | input | W (32) | Data word to be shifted |
| op_kind | input | 3 | Shift kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 carry rotate |
| op_amount | input | AMT_W (8) | Shift count, 0 up to 2^AMT_W-1 |
| carry_in | input | 1 | Current carry flag |
| shift_out | output | W (32) | Shifted word |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
The bench sweeps every count from 0 to 255 for all eight kind codes, with both carry values and a set of word patterns that includes a set sign bit, a clear sign bit, all ones and all zeros. It targets the points where counts change meaning: 0, W-1, W, W+1, and multiples of W.

Each of these points exposes a specific error. A design that wraps the count modulo W for logical shifts would return the word unchanged at 32 instead of zero. An off-by-one in carry selection shows up as the wrong carry at counts 1 and W-1. Returning a stale bit above W, instead of 0, breaks R9. A rotate that treats 32 like 0 would pass the old carry through instead of bit W-1. The carry rotate is checked with counts that would otherwise select other behaviour, to confirm that it ignores the count.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

endpackage

// File: rtl/bsh_stage_chain.sv
// Logarithmic right shifter: one stage per count bit, each stage moving
// the word by a power of two. Vacated bits take either the wrapped bits
// (rotate) or a single fill value.
module bsh_stage_chain #(
  parameter int W   = 32,
  parameter int LOG = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [LOG-1:0] amt,
  input  logic           rotate,
  input  logic           fill,
  output logic [W-1:0]   dout
);

  logic [LOG:0][W-1:0] stg;

  assign stg[0] = din;

  for (genvar k = 0; k < LOG; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0] wrap;
    assign wrap       = rotate ? stg[k][S-1:0] : {S{fill}};
    assign stg[k+1]   = amt[k] ? {wrap, stg[k][W-1:S]} : stg[k];
  end

  assign dout = stg[LOG];

endmodule

// File: rtl/bsh_bit_pick.sv
// Selects one bit of a word by index; used to recover the last bit
// shifted out.
module bsh_bit_pick #(
  parameter int W   = 32,
  parameter int LOG = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [LOG-1:0] idx,
  output logic           bit_o
);

  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (idx == LOG'(i)) bit_o = din[i];
    end
  end

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     op_value,
  input  logic [2:0]       op_kind,
  input  logic [AMT_W-1:0] op_amount,
  input  logic             carry_in,
  output logic [W-1:0]     shift_out,
  output logic             carry_out
);

  localparam int LOG = $clog2(W);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(W);

  shift_kind_e kind;
  assign kind = shift_kind_e'(op_kind);

  // Count classification
  logic           amt_zero, amt_eq, amt_over, amt_ge;
  logic [LOG-1:0] low, low_m1;
  assign amt_zero = (op_amount == '0);
  assign amt_eq   = (op_amount == AMT_FULL);
  assign amt_over = (op_amount >  AMT_FULL);
  assign amt_ge   = amt_eq | amt_over;
  assign low      = op_amount[LOG-1:0];
  assign low_m1   = low - LOG'(1);

  // Left shifts run through the right-shift chain on a mirrored word
  logic [W-1:0] val_rev, chain_in, chain_out, chain_rev, shaped;
  logic         is_left, sign, picked;

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign val_rev[i]   = op_value[W-1-i];
    assign chain_rev[i] = chain_out[W-1-i];
  end

  assign is_left  = (kind == SK_LSL);
  assign sign     = op_value[W-1];
  assign chain_in = is_left ? val_rev : op_value;

  bsh_stage_chain #(.W(W), .LOG(LOG)) u_chain (
    .din    (chain_in),
    .amt    (low),
    .rotate (kind == SK_ROR),
    .fill   ((kind == SK_ASR) & sign),
    .dout   (chain_out)
  );

  bsh_bit_pick #(.W(W), .LOG(LOG)) u_pick (
    .din   (chain_in),
    .idx   (low_m1),
    .bit_o (picked)
  );

  assign shaped = is_left ? chain_rev : chain_out;

  // Result and carry selection
  always_comb begin
    shift_out = op_value;
    carry_out = carry_in;
    if (kind == SK_RRX) begin
      shift_out = {carry_in, op_value[W-1:1]};
      carry_out = op_value[0];
    end else if (!amt_zero) begin
      unique case (kind)
        SK_LSL, SK_LSR: begin
          if (amt_over) begin
            shift_out = '0;
            carry_out = 1'b0;
          end else if (amt_eq) begin
            shift_out = '0;
            carry_out = is_left ? op_value[0] : op_value[W-1];
          end else begin
            shift_out = shaped;
            carry_out = picked;
          end
        end
        SK_ASR: begin
          if (amt_ge) begin
            shift_out = {W{sign}};
            carry_out = sign;
          end else begin
            shift_out = shaped;
            carry_out = picked;
          end
        end
        SK_ROR: begin
          if (low == '0) begin
            shift_out = op_value;
            carry_out = sign;
          end else begin
            shift_out = shaped;
            carry_out = picked;
          end
        end
        default: begin
          shift_out = op_value;
          carry_out = carry_in;
        end
      endcase
    end
  end

  // Checks at the port boundary
  always_comb begin
    if (amt_zero && op_kind != 3'd4) begin
      a_r1_zero_pass: assert (shift_out == op_value && carry_out == carry_in)
        else $error("R1 zero count did not pass through");
    end
    if (op_kind == 3'd4) begin
      a_r7_rrx: assert (shift_out[W-1] == carry_in && carry_out == op_value[0]
                        && shift_out[W-2:0] == op_value[W-1:1])
        else $error("R7 carry rotate wrong");
    end
    if ((op_kind == 3'd0 || op_kind == 3'd1) && amt_over) begin
      a_r9_over_zero: assert (shift_out == '0 && carry_out == 1'b0)
        else $error("R9 oversized logical shift not zero");
    end
    if (op_kind == 3'd2 && amt_ge) begin
      a_r10_asr_fill: assert (shift_out == {W{op_value[W-1]}} && carry_out == op_value[W-1])
        else $error("R10 oversized arithmetic shift wrong");
    end
    if (op_kind == 3'd3) begin
      a_r5_ror_ones: assert ($countones(shift_out) == $countones(op_value))
        else $error("R5 rotate changed bit count");
    end
    if (op_kind == 3'd0 && !amt_zero) begin
      a_r2_lsl_lsb: assert (shift_out[0] == 1'b0)
        else $error("R2 left shift did not clear bit 0");
    end
    if (op_kind > 3'd4) begin
      a_r11_unused: assert (shift_out == op_value && carry_out == carry_in)
        else $error("R11 unused kind altered data");
    end
  end

endmodule

// File: tb/barrel_shift_unit_test.sv
module barrel_shift_unit_test;

  localparam int W = 32;
  localparam int AMT_W = 8;

  logic clk;
  logic rst_n;
  logic [W-1:0]     op_value;
  logic [2:0]       op_kind;
  logic [AMT_W-1:0] op_amount;
  logic             carry_in;
  logic [W-1:0]     shift_out;
  logic             carry_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  barrel_shift_unit #(.W(W), .AMT_W(AMT_W)) uut (
    .op_value  (op_value),
    .op_kind   (op_kind),
    .op_amount (op_amount),
    .carry_in  (carry_in),
    .shift_out (shift_out),
    .carry_out (carry_out)
  );

  // Expected {carry, result} computed arithmetically
  function automatic logic [W:0] model(input logic [W-1:0] v, input int kind,
                                       input int n, input logic cin);
    logic [2*W:0]        tl;
    logic [W:0]          tr;
    logic signed [W:0]   ts;
    int                  m;
    if (kind == 4) return {v[0], cin, v[W-1:1]};
    if (kind > 4 || n == 0) return {cin, v};
    case (kind)
      0: begin
        tl = {{(W+1){1'b0}}, v} << n;
        return {tl[W], tl[W-1:0]};
      end
      1: begin
        tr = {v, 1'b0} >> n;
        return {tr[0], tr[W:1]};
      end
      2: begin
        ts = $signed({v, 1'b0}) >>> n;
        return {ts[0], ts[W:1]};
      end
      default: begin
        m = n % W;
        if (m == 0) return {v[W-1], v};
        return {v[m-1], (v >> m) | (v << (W - m))};
      end
    endcase
  endfunction

  function automatic string req_of(input int kind, input int n);
    if (kind == 4) return "R7";
    if (kind > 4) return "R11";
    if (n == 0) return "R1";
    case (kind)
      0, 1: return (n < W) ? (kind == 0 ? "R2" : "R3") : (n == W ? "R8" : "R9");
      2: return (n < W) ? "R4" : "R10";
      default: return (n % W == 0) ? "R6" : "R5";
    endcase
  endfunction

  task automatic check(input logic [W:0] exp, input string req);
    n_checks++;
    if ({carry_out, shift_out} !== exp) begin
      n_fails++;
      $display("FAIL %s kind=%0d amt=%0d val=%h cin=%b: got c=%b r=%h, expected c=%b r=%h",
               req, op_kind, op_amount, op_value, carry_in,
               carry_out, shift_out, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic apply(input logic [W-1:0] v, input int kind, input int n, input logic cin);
    @(posedge clk);
    op_value  = v;
    op_kind   = 3'(kind);
    op_amount = AMT_W'(n);
    carry_in  = cin;
    @(negedge clk);
    check(model(v, kind, n, cin), req_of(kind, n));
  endtask

  initial begin
    logic [W-1:0] pats [8];
    logic [W-1:0] lfsr;
    rst_n     = 1'b0;
    op_value  = '0;
    op_kind   = '0;
    op_amount = '0;
    carry_in  = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle inputs give a zero result and zero carry
    check({1'b0, {W{1'b0}}}, "R1");

    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h0000_0000;
    pats[4] = 32'h1234_5678;
    pats[5] = 32'hA5C3_0F96;
    lfsr    = 32'hACE1_2469;
    for (int p = 6; p < 8; p++) begin
      for (int s = 0; s < 37; s++)
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pats[p] = lfsr;
    end

    // Sweep: R1..R11 across all kinds, counts, carries and patterns
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < (1 << AMT_W); n++)
        for (int c = 0; c < 2; c++)
          for (int p = 0; p < 8; p++)
            apply(pats[p], k, n, c[0]);

    // Targeted corners: R8 carry at exactly W, R6 rotate by 2W
    apply(32'h0000_0001, 0, W, 1'b0);
    apply(32'h8000_0000, 1, W, 1'b0);
    apply(32'h8000_0000, 3, 2 * W, 1'b0);
    apply(32'h8000_0000, 2, W + 5, 1'b0);
    apply(32'h0000_0001, 4, W, 1'b1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 200000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule